// File: doc/BRIEF.md
# Embedded Sync Code Parser and Channel Demultiplexer

This block takes an aligned byte stream, one byte per cycle when `in_valid` is high, and finds the four-byte embedded sync codes inside it. Each sync code is a fixed three-byte lead-in followed by a code byte. The code byte names a logical channel and a code kind: line open, line close, frame open or frame close. The block tracks the frame and line state of every channel on its own. It forwards payload bytes only while the addressed channel is inside a line. Each byte goes out on that channel's own valid strobe.

A three-byte holding window keeps the lead-in bytes of a code out of the payload path. A payload byte therefore appears at the outputs one cycle after the third accepted byte that follows it. Decoded codes come out as single-cycle event pulses, with `out_ch` giving the channel. A malformed code, a code that arrives out of order, or a frame whose payload length is not a whole number of 16-byte blocks raises its own error pulse.

Top module: `embsync_demux`

## Requirements
- R1: While reset is held and in the first cycle after it is released, every valid strobe, event pulse and error pulse is low.
- R2: A sync code is the accepted bytes FF, 00, 00 and then a code byte. The event pulse for it appears in the cycle after the code byte is accepted, with `out_ch` equal to the code byte's upper nibble. None of the four code bytes is ever forwarded as payload.
- R3: The lower nibble of the code byte selects the kind: 0 gives `ev_sol`, 1 gives `ev_eol`, 2 gives `ev_sof` and 3 gives `ev_eof`.
- R4: Within a line, payload bytes are forwarded in arrival order on `out_byte`, with exactly one bit of `out_vld` set, at the position of the channel whose line is open. A byte is presented in the cycle after the third accepted byte that follows it.
- R5: Bytes received during line blanking (line close to line open) or frame blanking (frame close to frame open) are not forwarded.
- R6: A code byte whose upper nibble is 8 or more, or whose lower nibble is 4 or more, gives a one-cycle `err_code` pulse and no event. It leaves all channel state as it was, so a line that is open stays open.
- R7: A line open, line close or frame close for a channel that is not in a frame, and a frame open for a channel already in a frame, each give a one-cycle `err_seq` pulse and no event. Such a code is discarded, so a rejected line open forwards no payload.
- R8: Each channel keeps its own frame and line state. A code for one channel never changes another channel's state, so streams from several channels can be interleaved.
- R9: Each channel counts the payload bytes it forwards within a frame. On an accepted frame close, `err_size` pulses together with `ev_eof` when that count is not a multiple of 16.
- R10: A frame open also opens the first line, and a frame close also closes the last line and the frame. No separate line codes are needed at the frame edges.
- R11: A cycle with `in_valid` low changes nothing, whatever `in_byte` holds. The next cycle has no valid strobe and no event or error pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | `in_byte` carries a stream byte this cycle |
| in_byte | input | 8 | Aligned stream byte |
| out_vld | output | NCH | One strobe per channel, at most one high, marks a forwarded payload byte |
| out_byte | output | 8 | Forwarded payload byte |
| out_ch | output | CHW = clog2(NCH) | Channel of the current event or payload byte |
| ev_sof | output | 1 | Frame open accepted |
| ev_eof | output | 1 | Frame close accepted |
| ev_sol | output | 1 | Line open accepted |
| ev_eol | output | 1 | Line close accepted |
| err_code | output | 1 | Malformed code byte discarded |
| err_seq | output | 1 | Out-of-order code discarded |
| err_size | output | 1 | Frame payload length not a multiple of 16 bytes |

## Verification
The hardest case to reach is a line close whose lead-in bytes arrive while the last three payload bytes of the line are still in the holding window. Those bytes must drain to the right channel before the code takes effect, and no lead-in byte may leak out. Every frame scenario in the bench therefore ends a line directly after its payload, with no spacer bytes. It also checks the exact count and order of the forwarded bytes. Interleaving channel 4 and channel 5 lines inside overlapping frames exercises the separate per-channel state. A run with idle cycles full of FF/00 junk shows that the lead-in match only ever sees accepted bytes.

// File: rtl/embsync_pkg.sv
package embsync_pkg;

  typedef enum logic [1:0] {
    K_LINE_OPEN   = 2'd0,
    K_LINE_CLOSE  = 2'd1,
    K_FRAME_OPEN  = 2'd2,
    K_FRAME_CLOSE = 2'd3
  } kind_t;

  // three accepted bytes form the sync lead-in
  function automatic logic lead_match(input logic [7:0] b0, input logic [7:0] b1,
                                      input logic [7:0] b2);
    return (b0 == 8'hFF) && (b1 == 8'h00) && (b2 == 8'h00);
  endfunction

  // code byte legality: channel below the channel count, kind one of four
  function automatic logic code_legal(input logic [3:0] ch_nib, input logic [3:0] kind_nib,
                                      input int unsigned nch);
    return (32'(ch_nib) < nch) && (kind_nib < 4'd4);
  endfunction

endpackage

// File: rtl/embsync_window.sv
module embsync_window
  import embsync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic       code_hit,
  output logic [7:0] code_byte,
  output logic       pay_vld,
  output logic [7:0] pay_byte
);
  localparam int LEAD = 3;

  logic [7:0]      win [LEAD];   // index 0 is the oldest byte
  logic [LEAD-1:0] wv;

  assign code_hit  = in_valid && (&wv) && lead_match(win[0], win[1], win[2]);
  assign code_byte = in_byte;
  assign pay_vld   = in_valid && !code_hit && wv[0];
  assign pay_byte  = win[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wv <= '0;
      for (int i = 0; i < LEAD; i++) win[i] <= '0;
    end else if (in_valid) begin
      if (code_hit) begin
        wv <= '0;
      end else begin
        wv <= {1'b1, wv[LEAD-1:1]};
        for (int i = 0; i < LEAD-1; i++) win[i] <= win[i+1];
        win[LEAD-1] <= in_byte;
      end
    end
  end

  // R2: a detected code empties the window, so no lead-in byte reaches payload
  assert_flush_after_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    code_hit |=> (wv == '0) && !pay_vld);

endmodule

// File: rtl/embsync_track.sv
module embsync_track
  import embsync_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int FRAME_BYTES = 16,
  localparam int CHW        = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CNTW       = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           code_hit,
  input  logic [7:0]     code_byte,
  input  logic           pay_vld,
  output logic           fwd,
  output logic [CHW-1:0] fwd_ch,
  output logic           ev_fire,
  output kind_t          ev_kind,
  output logic [CHW-1:0] ev_ch,
  output logic           bad_code,
  output logic           bad_seq,
  output logic           bad_size,
  output logic [NCH-1:0] frame_q,
  output logic [NCH-1:0] line_q
);

  logic [NCH-1:0][CNTW-1:0] cnt_q;
  logic [CHW-1:0]           cur_q;
  logic                     legal, order_ok;

  function automatic logic frame_aligned(input logic [CNTW-1:0] c);
    return c == '0;
  endfunction

  function automatic logic [CNTW-1:0] next_count(input logic [CNTW-1:0] c);
    return (c == CNTW'(FRAME_BYTES-1)) ? '0 : c + 1'b1;
  endfunction

  assign legal   = code_legal(code_byte[7:4], code_byte[3:0], NCH);
  assign ev_ch   = code_byte[CHW+3:4];
  assign ev_kind = kind_t'(code_byte[1:0]);

  always_comb begin
    if (ev_kind == K_FRAME_OPEN) order_ok = !frame_q[ev_ch];
    else                         order_ok = frame_q[ev_ch];
  end

  assign ev_fire  = code_hit && legal && order_ok;
  assign bad_code = code_hit && !legal;
  assign bad_seq  = code_hit && legal && !order_ok;
  assign bad_size = ev_fire && (ev_kind == K_FRAME_CLOSE) && !frame_aligned(cnt_q[ev_ch]);
  assign fwd      = pay_vld && line_q[cur_q];
  assign fwd_ch   = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      line_q  <= '0;
      cnt_q   <= '0;
      cur_q   <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (ev_fire && ev_ch == CHW'(c)) begin
          unique case (ev_kind)
            K_LINE_OPEN:   line_q[c] <= 1'b1;
            K_LINE_CLOSE:  line_q[c] <= 1'b0;
            K_FRAME_OPEN:  begin frame_q[c] <= 1'b1; line_q[c] <= 1'b1; cnt_q[c] <= '0; end
            K_FRAME_CLOSE: begin frame_q[c] <= 1'b0; line_q[c] <= 1'b0; cnt_q[c] <= '0; end
          endcase
        end else if (fwd && cur_q == CHW'(c)) begin
          cnt_q[c] <= next_count(cnt_q[c]);
        end
      end
      if (ev_fire && (ev_kind == K_LINE_OPEN || ev_kind == K_FRAME_OPEN)) cur_q <= ev_ch;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R8: a code for another channel leaves this channel's state alone
    assert_other_channel_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_fire && ev_ch != CHW'(g)) |=> $stable(frame_q[g]) && $stable(line_q[g]));
    // R10: a line can only be open inside a frame
    assert_line_inside_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
      line_q[g] |-> frame_q[g]);
  end

endmodule

// File: rtl/embsync_demux.sv
module embsync_demux
  import embsync_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int FRAME_BYTES = 16,
  localparam int CHW        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [7:0]     in_byte,
  output logic [NCH-1:0] out_vld,
  output logic [7:0]     out_byte,
  output logic [CHW-1:0] out_ch,
  output logic           ev_sof,
  output logic           ev_eof,
  output logic           ev_sol,
  output logic           ev_eol,
  output logic           err_code,
  output logic           err_seq,
  output logic           err_size
);

  logic           code_hit, pay_vld, fwd, ev_fire, bad_code, bad_seq, bad_size;
  logic [7:0]     code_byte, pay_byte;
  logic [CHW-1:0] fwd_ch, ev_ch;
  kind_t          ev_kind;
  logic [NCH-1:0] frame_q, line_q;

  embsync_window u_window (
    .clk, .rst_n, .in_valid, .in_byte,
    .code_hit, .code_byte, .pay_vld, .pay_byte
  );

  embsync_track #(.NCH(NCH), .FRAME_BYTES(FRAME_BYTES)) u_track (
    .clk, .rst_n, .code_hit, .code_byte, .pay_vld,
    .fwd, .fwd_ch, .ev_fire, .ev_kind, .ev_ch,
    .bad_code, .bad_seq, .bad_size, .frame_q, .line_q
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= '0;
      out_byte <= '0;
      out_ch   <= '0;
      ev_sof   <= 1'b0;
      ev_eof   <= 1'b0;
      ev_sol   <= 1'b0;
      ev_eol   <= 1'b0;
      err_code <= 1'b0;
      err_seq  <= 1'b0;
      err_size <= 1'b0;
    end else begin
      out_vld  <= fwd ? (NCH'(1) << fwd_ch) : '0;
      if (fwd) out_byte <= pay_byte;
      if (code_hit)  out_ch <= ev_ch;
      else if (fwd)  out_ch <= fwd_ch;
      ev_sol   <= ev_fire && (ev_kind == K_LINE_OPEN);
      ev_eol   <= ev_fire && (ev_kind == K_LINE_CLOSE);
      ev_sof   <= ev_fire && (ev_kind == K_FRAME_OPEN);
      ev_eof   <= ev_fire && (ev_kind == K_FRAME_CLOSE);
      err_code <= bad_code;
      err_seq  <= bad_seq;
      err_size <= bad_size;
    end
  end

  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_vld));

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    assert_data_only_in_line_R4: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld[g] |-> line_q[g]);
  end

  assert_size_with_eof_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_size |-> ev_eof);

  assert_bad_code_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_code |-> !(ev_sof || ev_eof || ev_sol || ev_eol) && (out_vld == '0));

  assert_sof_opens_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sof |-> frame_q[out_ch] && line_q[out_ch]);

  assert_eof_closes_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_eof |-> !frame_q[out_ch] && !line_q[out_ch]);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (out_vld == '0) && !(ev_sof || ev_eof || ev_sol || ev_eol)
                  && !(err_code || err_seq || err_size));

endmodule

// File: tb/sim_embsync_demux.sv
`timescale 1ns/1ps
module sim_embsync_demux;

  localparam int NCH = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic [7:0]     in_byte;
  logic [NCH-1:0] out_vld;
  logic [7:0]     out_byte;
  logic [2:0]     out_ch;
  logic           ev_sof, ev_eof, ev_sol, ev_eol, err_code, err_seq, err_size;

  int checks = 0;
  int fails  = 0;
  bit gap    = 1'b0;

  logic [10:0] dq [$];   // {channel, byte}
  logic [7:0]  evq [$];  // {kind, channel}
  int n_ec, n_es, n_ez;

  always #2.5 clk = ~clk;

  embsync_demux #(.NCH(NCH), .FRAME_BYTES(16)) u0 (
    .clk, .rst_n, .in_valid, .in_byte, .out_vld, .out_byte, .out_ch,
    .ev_sof, .ev_eof, .ev_sol, .ev_eol, .err_code, .err_seq, .err_size
  );

  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < NCH; c++) if (out_vld[c]) dq.push_back({3'(c), out_byte});
      if (ev_sol) evq.push_back({3'd0, 2'd0, out_ch});
      if (ev_eol) evq.push_back({3'd0, 2'd1, out_ch});
      if (ev_sof) evq.push_back({3'd0, 2'd2, out_ch});
      if (ev_eof) evq.push_back({3'd0, 2'd3, out_ch});
      n_ec += int'(err_code);
      n_es += int'(err_seq);
      n_ez += int'(err_size);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_logs();
    dq.delete(); evq.delete(); n_ec = 0; n_es = 0; n_ez = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1; in_byte = b;
    @(posedge clk); #1;
    in_valid = 1'b0;
    if (gap) begin
      in_byte = 8'hFF; @(posedge clk); #1;
      in_byte = 8'h00; @(posedge clk); #1;
    end
  endtask

  task automatic code(input logic [3:0] ch, input logic [3:0] kind);
    send(8'hFF); send(8'h00); send(8'h00); send({ch, kind});
  endtask

  task automatic payload(input logic [7:0] base, input int n);
    for (int i = 0; i < n; i++) send(base + 8'(i));
  endtask

  task automatic expect_bytes(input string tag, input int off, input logic [2:0] ch,
                              input logic [7:0] base, input int n);
    for (int i = 0; i < n; i++)
      chk(dq[off+i] == {ch, base + 8'(i)}, tag, int'(dq[off+i]), int'({ch, base + 8'(i)}));
  endtask

  task automatic t_reset();
    chk(out_vld == '0, "R1 strobes", int'(out_vld), 0);
    chk(!(ev_sof || ev_eof || ev_sol || ev_eol), "R1 events",
        int'({ev_sof, ev_eof, ev_sol, ev_eol}), 0);
    chk(!(err_code || err_seq || err_size), "R1 errors", int'({err_code, err_seq, err_size}), 0);
  endtask

  task automatic t_basic();
    clear_logs();
    code(4'd2, 4'd2);
    chk(ev_sof && out_ch == 3'd2, "R2 event timing", int'({ev_sof, out_ch}), 'hA);
    payload(8'h10, 16);
    code(4'd2, 4'd3);
    chk(ev_eof && !err_size, "R9 aligned frame", int'({ev_eof, err_size}), 2);
    settle();
    chk(evq.size() == 2, "R3 event count", evq.size(), 2);
    chk(evq[0] == 8'h12 && evq[1] == 8'h1A, "R3 kinds", int'({evq[0], evq[1]}), 'h121A);
    chk(dq.size() == 16, "R2 no lead-in leak", dq.size(), 16);
    expect_bytes("R4 order", 0, 3'd2, 8'h10, 16);
  endtask

  task automatic t_blank();
    clear_logs();
    code(4'd0, 4'd2); payload(8'h30, 16); code(4'd0, 4'd1);
    payload(8'hAA, 5);
    code(4'd0, 4'd0); payload(8'h60, 16); code(4'd0, 4'd3);
    payload(8'h77, 6);
    settle();
    chk(dq.size() == 32, "R5 blanking dropped", dq.size(), 32);
    expect_bytes("R5 line 1", 0, 3'd0, 8'h30, 16);
    expect_bytes("R5 line 2", 16, 3'd0, 8'h60, 16);
    chk(evq.size() == 4 && evq[0] == 8'h10 && evq[1] == 8'h08 && evq[2] == 8'h00 && evq[3] == 8'h18,
        "R10 frame edges", evq.size(), 4);
    chk(n_ec + n_es + n_ez == 0, "R10 no errors", n_ec + n_es + n_ez, 0);
  endtask

  task automatic t_size();
    clear_logs();
    code(4'd1, 4'd2); payload(8'h70, 5); code(4'd1, 4'd3);
    chk(err_size && ev_eof, "R9 short frame", int'({err_size, ev_eof}), 3);
    settle();
    chk(n_ez == 1, "R9 single pulse", n_ez, 1);
  endtask

  task automatic t_badcode();
    clear_logs();
    code(4'd8, 4'd2);
    chk(err_code && !ev_sof, "R6 channel 8", int'({err_code, ev_sof}), 2);
    code(4'd1, 4'd5);
    chk(err_code && !ev_eol, "R6 kind 5", int'({err_code, ev_eol}), 2);
    code(4'd1, 4'd2); payload(8'h20, 16);
    code(4'd1, 4'd12);
    chk(err_code && out_vld == '0, "R6 mid-line", int'(err_code), 1);
    payload(8'h40, 16); code(4'd1, 4'd3);
    settle();
    chk(n_ec == 3 && n_ez == 0, "R6 counts", n_ec * 16 + n_ez, 'h30);
    chk(dq.size() == 32, "R6 line kept open", dq.size(), 32);
    expect_bytes("R6 data", 16, 3'd1, 8'h40, 16);
    chk(evq.size() == 2, "R6 no stray events", evq.size(), 2);
  endtask

  task automatic t_seq();
    clear_logs();
    code(4'd3, 4'd0);
    chk(err_seq && !ev_sol, "R7 line open outside frame", int'({err_seq, ev_sol}), 2);
    payload(8'h51, 6);
    code(4'd3, 4'd1);
    code(4'd3, 4'd3);
    settle();
    chk(dq.size() == 0, "R7 nothing forwarded", dq.size(), 0);
    code(4'd3, 4'd2);
    code(4'd3, 4'd2);
    chk(err_seq && !ev_sof, "R7 nested frame open", int'({err_seq, ev_sof}), 2);
    payload(8'h90, 16); code(4'd3, 4'd3);
    settle();
    chk(n_es == 4, "R7 error count", n_es, 4);
    chk(evq.size() == 2 && dq.size() == 16, "R7 frame intact", dq.size(), 16);
  endtask

  task automatic t_interleave();
    clear_logs();
    code(4'd4, 4'd2); payload(8'h80, 16); code(4'd4, 4'd1);
    code(4'd5, 4'd2); payload(8'hA0, 16); code(4'd5, 4'd1);
    code(4'd4, 4'd0); payload(8'hC0, 16); code(4'd4, 4'd3);
    code(4'd5, 4'd0); payload(8'hE0, 16); code(4'd5, 4'd3);
    settle();
    chk(dq.size() == 64, "R8 byte total", dq.size(), 64);
    expect_bytes("R8 ch4 a", 0, 3'd4, 8'h80, 16);
    expect_bytes("R8 ch5 a", 16, 3'd5, 8'hA0, 16);
    expect_bytes("R8 ch4 b", 32, 3'd4, 8'hC0, 16);
    expect_bytes("R8 ch5 b", 48, 3'd5, 8'hE0, 16);
    chk(n_es == 0 && n_ez == 0 && evq.size() == 8, "R8 independent state", n_es, 0);
  endtask

  task automatic t_gaps();
    clear_logs();
    gap = 1'b1;
    code(4'd6, 4'd2); payload(8'h01, 16); code(4'd6, 4'd3);
    gap = 1'b0;
    settle();
    chk(dq.size() == 16, "R11 idle junk ignored", dq.size(), 16);
    expect_bytes("R11 data", 0, 3'd6, 8'h01, 16);
    chk(evq.size() == 2 && n_ec + n_es + n_ez == 0, "R11 events", evq.size(), 2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
    repeat (3) @(posedge clk);
    t_reset();
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_basic();
    t_blank();
    t_size();
    t_badcode();
    t_seq();
    t_interleave();
    t_gaps();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule